// File: doc/BRIEF.md
# Layer 3/4 Frame Filter Decision Unit

This unit decides whether a received Ethernet frame is forwarded or dropped. It does not parse the frame. A parser upstream supplies the header fields: an IPv4-present flag, the IP protocol number, the source and destination IPv4 addresses, and the source and destination TCP/UDP ports. These fields arrive together with a one-cycle header strobe. The unit compares the fields against a bank of programmable filters. Each filter has four per-field enable bits, four compare values and an invert option.

One clock after the strobe, the unit registers a verdict and presents it with a one-cycle valid pulse. The verdict contains four outputs:
- a forward/drop bit;
- a truncate flag, which tells the receive path whether a dropped frame is cut short with abort status or discarded silently;
- the index of the filter that accepted the frame;
- a valid bit for that index.

When several filters accept the frame, the lowest-numbered one wins. IPv4 traffic that is neither TCP nor UDP skips filtering unless a configuration bit orders it dropped. All configuration is applied through plain input ports, and it is assumed stable while frames are evaluated.

Top module: `l34_frame_filter`

## Requirements
- R1: While `rst_n` is low, `dec_valid`, `dec_forward`, `dec_truncate`, `dec_hit_valid` and `dec_hit_idx` are all 0 one clock later.
- R2: `dec_valid` is high for exactly the cycle after each cycle in which `hdr_valid` is high, and it is low otherwise. The other outputs carry that frame's verdict in the same cycle.
- R3: A frame with `ipv4_present` = 0 is forwarded with `dec_hit_valid` = 0, whatever the filter configuration.
- R4: An IPv4 frame whose protocol is neither 6 (TCP) nor 17 (UDP) is forwarded with `dec_hit_valid` = 0 when `cfg_drop_other_ip` = 0.
- R5: An IPv4 frame whose protocol is neither 6 nor 17 is dropped with `dec_hit_valid` = 0 when `cfg_drop_other_ip` = 1.
- R6: Filter i is active when any of its enable bits `flt_field_en[4*i+3:4*i]` is set. The bits mean: bit 0 source IP, bit 1 destination IP, bit 2 source port, bit 3 destination port. An active filter hits only when every enabled field equals its compare value. A filter with no enabled fields never hits.
- R7: If no filter is active, every TCP/UDP IPv4 frame is forwarded with `dec_hit_valid` = 0.
- R8: A filter accepts a frame when it is active and the frame hits it, or, with `flt_invert[i]` = 1, when it is active and the frame does not hit it. If any filter accepts, the frame is forwarded with `dec_hit_valid` = 1, and `dec_hit_idx` is the lowest index that accepted.
- R9: When at least one filter is active and none accepts a TCP/UDP IPv4 frame, the frame is dropped with `dec_hit_valid` = 0.
- R10: `dec_truncate` equals `cfg_abort_mode` when the verdict is drop, and it is 0 when the verdict is forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Header fields valid strobe |
| ipv4_present | input | 1 | Frame carries an IPv4 header |
| ip_proto | input | 8 | IP protocol number |
| src_ip | input | 32 | Source IPv4 address |
| dst_ip | input | 32 | Destination IPv4 address |
| src_port | input | 16 | Source TCP/UDP port |
| dst_port | input | 16 | Destination TCP/UDP port |
| cfg_drop_other_ip | input | 1 | Drop IPv4 frames that are neither TCP nor UDP |
| cfg_abort_mode | input | 1 | 1: dropped frames are truncated with abort status; 0: discarded |
| flt_field_en | input | 16 | Four field-enable bits per filter |
| flt_invert | input | 4 | Per-filter inverse match |
| flt_src_ip | input | 128 | Per-filter source IP compare value |
| flt_dst_ip | input | 128 | Per-filter destination IP compare value |
| flt_src_port | input | 64 | Per-filter source port compare value |
| flt_dst_port | input | 64 | Per-filter destination port compare value |
| dec_valid | output | 1 | Verdict valid pulse |
| dec_forward | output | 1 | 1: forward, 0: drop |
| dec_truncate | output | 1 | Dropped frame is truncated with abort status |
| dec_hit_valid | output | 1 | A filter accepted the frame |
| dec_hit_idx | output | 2 | Index of the accepting filter |

## Verification
The whole verdict is held in one register stage, so a wrong internal value reaches the ports in the cycle right after the strobe, and that cycle is the only place to look. The kinds of fault that show up there are:
- a broken compare in one field, which flips the forward bit only on frames where that field decides the outcome;
- a wrong priority order, which leaves the forward bit correct but moves `dec_hit_idx` onto a higher filter;
- a mishandled inverse option or protocol bypass, which flips the verdict of whole classes of frames.

For these reasons the stimulus draws header fields from small pools of values that overlap with the filter compare values, so that hits, misses and multi-filter hits are all frequent.

// File: rtl/l34_filter_pkg.sv
// Package: shared widths, field-enable bit positions and protocol constants
// for the Layer 3/4 frame filter. Assumes IPv4 addressing only.
package l34_filter_pkg;
    localparam int IP_W    = 32;
    localparam int PORT_W  = 16;
    localparam int PROTO_W = 8;
    localparam int FIELDS  = 4;

    localparam int EN_SRC_IP   = 0;
    localparam int EN_DST_IP   = 1;
    localparam int EN_SRC_PORT = 2;
    localparam int EN_DST_PORT = 3;

    localparam logic [PROTO_W-1:0] PROTO_TCP = 8'd6;
    localparam logic [PROTO_W-1:0] PROTO_UDP = 8'd17;

    // Returns 1 when the protocol number names a transport the filters inspect.
    function automatic logic is_filterable(input logic [PROTO_W-1:0] proto);
        return (proto == PROTO_TCP) || (proto == PROTO_UDP);
    endfunction
endpackage

// File: rtl/l34_filter_match.sv
// Module: one filter slot. Compares the header fields against the slot's
// compare values under its field enables. It reports whether the slot is
// active (any field enabled) and whether it accepts the frame, with the
// invert option applied. Purely combinational; the caller qualifies the
// result with the frame class.
module l34_filter_match
    import l34_filter_pkg::*;
(
    input  logic [FIELDS-1:0] field_en,
    input  logic              invert,
    input  logic [IP_W-1:0]   cmp_src_ip,
    input  logic [IP_W-1:0]   cmp_dst_ip,
    input  logic [PORT_W-1:0] cmp_src_port,
    input  logic [PORT_W-1:0] cmp_dst_port,
    input  logic [IP_W-1:0]   src_ip,
    input  logic [IP_W-1:0]   dst_ip,
    input  logic [PORT_W-1:0] src_port,
    input  logic [PORT_W-1:0] dst_port,
    output logic              active,
    output logic              accept
);
    logic [FIELDS-1:0] field_ok;
    logic              hit;

    // Per-field compare; a disabled field never blocks the hit.
    always_comb begin
        field_ok[EN_SRC_IP]   = !field_en[EN_SRC_IP]   || (src_ip   == cmp_src_ip);
        field_ok[EN_DST_IP]   = !field_en[EN_DST_IP]   || (dst_ip   == cmp_dst_ip);
        field_ok[EN_SRC_PORT] = !field_en[EN_SRC_PORT] || (src_port == cmp_src_port);
        field_ok[EN_DST_PORT] = !field_en[EN_DST_PORT] || (dst_port == cmp_dst_port);
    end

    // Hit needs at least one enabled field and all enabled fields equal (R6).
    always_comb begin
        active = |field_en;
        hit    = active && (&field_ok);
        accept = active && (invert ? !hit : hit);
    end

    // An inactive slot must never accept, even when inverted (R6).
    always_comb begin
        assert_idle_slot_silent_R6: assert (active || !accept);
    end
endmodule

// File: rtl/l34_priority_pick.sv
// Module: lowest-index-wins selector over a request vector. Outputs a found
// flag and the index of the lowest set bit. Combinational; assumes N >= 2.
module l34_priority_pick #(
    parameter int N     = 4,
    localparam int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    req,
    output logic            found,
    output logic [IDXW-1:0] idx
);
    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                found = 1'b1;
                idx   = IDXW'(k);
            end
        end
    end

    // The chosen bit is set and no lower request exists (R8).
    always_comb begin
        if (found) begin
            assert_pick_lowest_R8: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
        end else begin
            assert_pick_none_R8: assert (req == '0);
        end
    end
endmodule

// File: rtl/l34_frame_filter.sv
// Module: Layer 3/4 frame filter decision unit (top). It classifies each
// header presented with hdr_valid:
//   - frames without IPv4, and non-TCP/UDP IPv4 frames, take the bypass path;
//   - TCP/UDP IPv4 frames run through NUM_FLT filter slots, and the lowest
//     accepting slot wins.
// The verdict is registered and shown one clock later with a dec_valid pulse.
// Assumes the configuration is stable while headers are evaluated.
// Synchronous active-low reset.
module l34_frame_filter
    import l34_filter_pkg::*;
#(
    parameter int NUM_FLT = 4,
    localparam int IDXW   = $clog2(NUM_FLT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hdr_valid,
    input  logic                        ipv4_present,
    input  logic [PROTO_W-1:0]          ip_proto,
    input  logic [IP_W-1:0]             src_ip,
    input  logic [IP_W-1:0]             dst_ip,
    input  logic [PORT_W-1:0]           src_port,
    input  logic [PORT_W-1:0]           dst_port,
    input  logic                        cfg_drop_other_ip,
    input  logic                        cfg_abort_mode,
    input  logic [NUM_FLT*FIELDS-1:0]   flt_field_en,
    input  logic [NUM_FLT-1:0]          flt_invert,
    input  logic [NUM_FLT*IP_W-1:0]     flt_src_ip,
    input  logic [NUM_FLT*IP_W-1:0]     flt_dst_ip,
    input  logic [NUM_FLT*PORT_W-1:0]   flt_src_port,
    input  logic [NUM_FLT*PORT_W-1:0]   flt_dst_port,
    output logic                        dec_valid,
    output logic                        dec_forward,
    output logic                        dec_truncate,
    output logic                        dec_hit_valid,
    output logic [IDXW-1:0]             dec_hit_idx
);
    logic [NUM_FLT-1:0] slot_active;
    logic [NUM_FLT-1:0] slot_accept;
    logic               pick_found;
    logic [IDXW-1:0]    pick_idx;

    logic               nxt_forward;
    logic               nxt_hit_valid;
    logic [IDXW-1:0]    nxt_hit_idx;

    // One compare slot per filter.
    for (genvar g = 0; g < NUM_FLT; g++) begin : g_slot
        l34_filter_match u_match (
            .field_en     (flt_field_en[g*FIELDS +: FIELDS]),
            .invert       (flt_invert[g]),
            .cmp_src_ip   (flt_src_ip[g*IP_W +: IP_W]),
            .cmp_dst_ip   (flt_dst_ip[g*IP_W +: IP_W]),
            .cmp_src_port (flt_src_port[g*PORT_W +: PORT_W]),
            .cmp_dst_port (flt_dst_port[g*PORT_W +: PORT_W]),
            .src_ip       (src_ip),
            .dst_ip       (dst_ip),
            .src_port     (src_port),
            .dst_port     (dst_port),
            .active       (slot_active[g]),
            .accept       (slot_accept[g])
        );
    end

    // Lowest-index accepting slot.
    l34_priority_pick #(.N(NUM_FLT)) u_pick (
        .req   (slot_accept),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Verdict: bypass paths first, then filter outcome (R3, R4, R5, R7, R8, R9).
    always_comb begin
        nxt_forward   = 1'b1;
        nxt_hit_valid = 1'b0;
        nxt_hit_idx   = '0;
        if (!ipv4_present) begin
            nxt_forward = 1'b1;
        end else if (!is_filterable(ip_proto)) begin
            nxt_forward = !cfg_drop_other_ip;
        end else if (slot_active == '0) begin
            nxt_forward = 1'b1;
        end else if (pick_found) begin
            nxt_forward   = 1'b1;
            nxt_hit_valid = 1'b1;
            nxt_hit_idx   = pick_idx;
        end else begin
            nxt_forward = 1'b0;
        end
    end

    // Register the verdict on each header strobe; dec_valid pulses once (R1, R2, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid     <= 1'b0;
            dec_forward   <= 1'b0;
            dec_truncate  <= 1'b0;
            dec_hit_valid <= 1'b0;
            dec_hit_idx   <= '0;
        end else begin
            dec_valid <= hdr_valid;
            if (hdr_valid) begin
                dec_forward   <= nxt_forward;
                dec_truncate  <= !nxt_forward && cfg_abort_mode;
                dec_hit_valid <= nxt_hit_valid;
                dec_hit_idx   <= nxt_hit_idx;
            end
        end
    end

    // Reset clears the valid pulse on the following edge.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !dec_valid);

    // Each strobe yields exactly one valid pulse one clock later.
    assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> dec_valid);
    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !dec_valid);

    // A filter index is reported only with a forward verdict.
    assert_hit_means_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_hit_valid |-> dec_forward);

    // Truncate never accompanies a forwarded frame.
    assert_truncate_only_on_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_forward |-> !dec_truncate);
endmodule

// File: tb/l34_frame_filter_test.sv
// Bench: directed corner cases followed by seeded random headers and
// configurations. Every verdict is compared against a reference function.
module l34_frame_filter_test;
    localparam int NF = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hdr_valid = 1'b0;
    logic         ipv4_present = 1'b0;
    logic [7:0]   ip_proto = '0;
    logic [31:0]  src_ip = '0, dst_ip = '0;
    logic [15:0]  src_port = '0, dst_port = '0;
    logic         cfg_drop_other_ip = 1'b0, cfg_abort_mode = 1'b0;
    logic [NF*4-1:0]  flt_field_en = '0;
    logic [NF-1:0]    flt_invert = '0;
    logic [NF*32-1:0] flt_src_ip = '0, flt_dst_ip = '0;
    logic [NF*16-1:0] flt_src_port = '0, flt_dst_port = '0;
    logic         dec_valid, dec_forward, dec_truncate, dec_hit_valid;
    logic [1:0]   dec_hit_idx;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    l34_frame_filter #(.NUM_FLT(NF)) uut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .ipv4_present(ipv4_present),
        .ip_proto(ip_proto), .src_ip(src_ip), .dst_ip(dst_ip), .src_port(src_port),
        .dst_port(dst_port), .cfg_drop_other_ip(cfg_drop_other_ip),
        .cfg_abort_mode(cfg_abort_mode), .flt_field_en(flt_field_en),
        .flt_invert(flt_invert), .flt_src_ip(flt_src_ip), .flt_dst_ip(flt_dst_ip),
        .flt_src_port(flt_src_port), .flt_dst_port(flt_dst_port),
        .dec_valid(dec_valid), .dec_forward(dec_forward), .dec_truncate(dec_truncate),
        .dec_hit_valid(dec_hit_valid), .dec_hit_idx(dec_hit_idx)
    );

    always #10 clk = ~clk;

    // Reference verdict, packed as {forward, truncate, hit_valid, idx[1:0]}.
    function automatic logic [4:0] expect_verdict();
        logic fwd, hv;
        logic [1:0] ix;
        bit any_active;
        fwd = 1'b1; hv = 1'b0; ix = 2'd0; any_active = 1'b0;
        if (ipv4_present && !(ip_proto == 8'd6 || ip_proto == 8'd17)) begin
            fwd = !cfg_drop_other_ip;
        end else if (ipv4_present) begin
            for (int i = NF - 1; i >= 0; i--) begin
                logic [3:0] en;
                bit h, acc;
                en = flt_field_en[i*4 +: 4];
                h = (en != 0)
                    && (!en[0] || src_ip   == flt_src_ip[i*32 +: 32])
                    && (!en[1] || dst_ip   == flt_dst_ip[i*32 +: 32])
                    && (!en[2] || src_port == flt_src_port[i*16 +: 16])
                    && (!en[3] || dst_port == flt_dst_port[i*16 +: 16]);
                acc = (en != 0) && (flt_invert[i] ? !h : h);
                if (en != 0) any_active = 1'b1;
                if (acc) begin hv = 1'b1; ix = 2'(i); end
            end
            fwd = !any_active || hv;
        end
        return {fwd, !fwd && cfg_abort_mode, hv, ix};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one header for one cycle and check the verdict a clock later.
    task automatic frame(input string req, input logic v4, input logic [7:0] pr,
                         input logic [31:0] sip, input logic [31:0] dip,
                         input logic [15:0] sp, input logic [15:0] dp);
        logic [4:0] exp;
        @(negedge clk);
        ipv4_present = v4; ip_proto = pr; src_ip = sip; dst_ip = dip;
        src_port = sp; dst_port = dp; hdr_valid = 1'b1;
        exp = expect_verdict();
        @(negedge clk);
        hdr_valid = 1'b0;
        check({req, " valid"}, 32'(dec_valid), 32'd1);
        check(req, 32'({dec_forward, dec_truncate, dec_hit_valid, dec_hit_idx}), 32'(exp));
        @(negedge clk);
        check({req, " R2 pulse ends"}, 32'(dec_valid), 32'd0);
    endtask

    task automatic set_flt(input int i, input logic [3:0] en, input logic inv,
                           input logic [31:0] sip, input logic [31:0] dip,
                           input logic [15:0] sp, input logic [15:0] dp);
        flt_field_en[i*4 +: 4] = en; flt_invert[i] = inv;
        flt_src_ip[i*32 +: 32] = sip; flt_dst_ip[i*32 +: 32] = dip;
        flt_src_port[i*16 +: 16] = sp; flt_dst_port[i*16 +: 16] = dp;
    endtask

    function automatic logic [31:0] pick_ip(input int unsigned r);
        return (r % 2 == 0) ? 32'h0A00_0001 : 32'h0A00_0002;
    endfunction
    function automatic logic [15:0] pick_port(input int unsigned r);
        return (r % 2 == 0) ? 16'd80 : 16'd443;
    endfunction

    localparam logic [31:0] IPA = 32'h0A00_0001, IPB = 32'h0A00_0002;

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        hdr_valid = 1'b1;                         // strobe during reset must be ignored
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 32'(dec_valid), 32'd0);
        check("R1 outputs in reset", 32'({dec_forward, dec_truncate, dec_hit_valid, dec_hit_idx}), 32'd0);
        hdr_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle", 32'(dec_valid), 32'd0);

        // R7: no filter active, TCP frame forwarded with no index.
        frame("R7 all disabled", 1'b1, 8'd6, IPA, IPB, 16'd80, 16'd443);

        // Filters: 0 = dst port 443, 1 = src ip A, 2 = dst ip B & src port 22, 3 = idle.
        set_flt(0, 4'b1000, 1'b0, '0, '0, '0, 16'd443);
        set_flt(1, 4'b0001, 1'b0, IPA, '0, '0, '0);
        set_flt(2, 4'b0110, 1'b0, '0, IPB, 16'd22, '0);
        set_flt(3, 4'b0000, 1'b1, '0, '0, '0, '0);     // inverted but idle: never accepts
        cfg_abort_mode = 1'b1;

        frame("R3 non-IPv4", 1'b0, 8'd6, IPB, IPA, 16'd1, 16'd2);
        frame("R4 ICMP bypass", 1'b1, 8'd1, IPB, IPA, 16'd1, 16'd2);
        cfg_drop_other_ip = 1'b1;
        frame("R5 ICMP dropped truncate R10", 1'b1, 8'd1, IPB, IPA, 16'd1, 16'd2);
        frame("R3 non-IPv4 with drop bit", 1'b0, 8'd50, IPB, IPA, 16'd1, 16'd2);
        cfg_drop_other_ip = 1'b0;
        frame("R8 filters 0 and 1 hit, idx 0", 1'b1, 8'd6, IPA, IPA, 16'd9, 16'd443);
        frame("R8 only filter 1, UDP", 1'b1, 8'd17, IPA, IPA, 16'd9, 16'd53);
        frame("R6 filter 2 both fields", 1'b1, 8'd6, IPB, IPB, 16'd22, 16'd53);
        frame("R6 filter 2 partial miss R9 drop", 1'b1, 8'd6, IPB, IPB, 16'd23, 16'd53);
        cfg_abort_mode = 1'b0;
        frame("R10 silent drop", 1'b1, 8'd17, IPB, IPA, 16'd23, 16'd53);

        // R8 inverse: filter 0 blocks dst port 443, the others are idle.
        set_flt(0, 4'b1000, 1'b1, '0, '0, '0, 16'd443);
        set_flt(1, 4'b0000, 1'b0, '0, '0, '0, '0);
        set_flt(2, 4'b0000, 1'b0, '0, '0, '0, '0);
        frame("R8 inverse hit blocks", 1'b1, 8'd6, IPA, IPB, 16'd5, 16'd443);
        frame("R8 inverse miss passes", 1'b1, 8'd6, IPA, IPB, 16'd5, 16'd80);

        // Back-to-back strobes: one pulse per strobe (R2).
        @(negedge clk);
        ipv4_present = 1'b0; hdr_valid = 1'b1;
        @(negedge clk);
        check("R2 back-to-back first", 32'(dec_valid), 32'd1);
        @(negedge clk);
        hdr_valid = 1'b0;
        check("R2 back-to-back second", 32'(dec_valid), 32'd1);
        @(negedge clk);
        check("R2 back-to-back end", 32'(dec_valid), 32'd0);

        // Seeded random configurations and headers.
        for (int n = 0; n < 400; n++) begin
            if (n % 20 == 0) begin
                for (int i = 0; i < NF; i++) begin
                    set_flt(i, 4'($urandom % 16), 1'($urandom % 4 == 0),
                            pick_ip($urandom), pick_ip($urandom),
                            pick_port($urandom), pick_port($urandom));
                end
                cfg_drop_other_ip = 1'($urandom);
                cfg_abort_mode = 1'($urandom);
            end
            begin
                logic [7:0] pr;
                case ($urandom % 4)
                    0: pr = 8'd6;
                    1: pr = 8'd17;
                    2: pr = 8'd6;
                    default: pr = 8'($urandom);
                endcase
                frame("R6 R8 R9 R10 random", 1'($urandom % 8 != 0), pr,
                      pick_ip($urandom), pick_ip($urandom),
                      pick_port($urandom), pick_port($urandom));
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule